// File: doc/BRIEF.md
# Register Splice and Byte-Align Execution Unit

This unit executes the bit-splicing group of a DSP instruction set extension in one registered step. Each operation builds a new value for the rt register out of two source operands. Part of the result comes from rt, shifted left or right. The vacated bit or byte positions are filled from rs, at a split point taken from the instruction word. The word forms compute inside the low 32 bits. When the doubleword forms are enabled, the datapath is 64 bits wide and each word result is sign-extended from bit 31.

The issue stage presents the instruction word, both operand values and a valid strobe. On the next clock edge the unit presents the new rt value, a write strobe and a reserved-instruction flag. Register file access, hazard handling and checking that the extension is enabled belong to the surrounding pipeline. A parameter selects a 32-bit build or a 64-bit build with the doubleword forms.

Top module: `dsp_splice_unit`

## Requirements
- R1: The unit acts only when the instruction has primary opcode 0x1F (bits [31:26]) and function code 0x31 (word group) or 0x35 (doubleword group) in bits [5:0]. Any other instruction produces neither a write strobe nor an exception. The operation selector is bits [10:6], the shift amount sa is bits [15:11] and the rt index is bits [20:16].
- R2: Word append (function 0x31, selector 0x00) gives rt shifted left by sa, with its low sa bits taken from the low sa bits of rs. The 32-bit result is sign-extended.
- R3: Word prepend (function 0x31, selector 0x01) gives the low 32 bits of rt, zero-extended and shifted right by sa, with its top sa bits taken from the low sa bits of rs. The result is sign-extended. When sa is 0, the result is rt sign-extended.
- R4: Byte align (function 0x31, selector 0x10) uses bp = sa[1:0]. For bp 0 or 2 the result is rt sign-extended from 32 bits. For bp 1 or 3 the result is (rt << 8·bp) | (rs[31:0] >> 8·(4−bp)), sign-extended from 32 bits.
- R5: Doubleword append (function 0x35, selector 0x00) gives the 64-bit rt shifted left by sa, with its low sa bits taken from rs. No sign extension is applied.
- R6: Word-amount prepend (function 0x35, selector 0x01) gives the 64-bit rt shifted right by sa, with its top sa bits taken from the low sa bits of rs. When sa is 0, rt is unchanged.
- R7: Doubleword prepend (function 0x35, selector 0x03) uses a shift of s = 32 + sa. It gives rt shifted right by s, with its top s bits taken from the low s bits of rs.
- R8: Doubleword byte align (function 0x35, selector 0x10) uses bp = sa[2:0]. For bp 0, 2 or 4 the result is rt unchanged. Otherwise it is (rt << 8·bp) | (rs >> 8·(8−bp)).
- R9: In a recognised group, any selector not listed above raises the reserved-instruction flag, asserts no write strobe and leaves the result output unchanged.
- R10: An instruction whose rt index is 0 is a no-op. It produces neither a write strobe nor an exception.
- R11: In the 32-bit build, function 0x35 is reserved and raises the exception flag.
- R12: The result, write strobe and exception flag appear on the clock edge that samples the valid strobe. Without valid, both flags are low. The two flags are never high together, and the result output changes only together with a write strobe.
- R13: After reset, the result is zero and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | XW (32 or 64) | Value of the rs register |
| rt_val | input | XW (32 or 64) | Current value of the rt register |
| out_rt | output | XW (32 or 64) | New rt value |
| out_we | output | 1 | Write out_rt into rt |
| out_ri | output | 1 | Reserved-instruction exception |

## Verification
The bench goes after the split-point extremes: sa of 0 and 31 for every splice form, and each byte offset of both align forms. A unit that shifts by the full width when sa is 0 would lose rt. One that treats every even offset as pass-through would get doubleword offset 6 wrong. The bench uses rt values with bit 31 set, so a missing or misplaced sign extension in the 64-bit build shows in the upper word. It also sends reserved selectors, rt index 0, foreign opcodes and the doubleword group to the 32-bit build. A decoder that confuses these would write when it must not, or raise the wrong flag.

// File: rtl/splice_pkg.sv
package splice_pkg;

   localparam logic [5:0] OPC_SPECIAL3 = 6'h1F;
   localparam logic [5:0] FN_WORD      = 6'h31;
   localparam logic [5:0] FN_DWORD     = 6'h35;

   // selector codes, bits [10:6]
   localparam logic [4:0] SEL_APPEND   = 5'h00;
   localparam logic [4:0] SEL_PREPEND  = 5'h01;
   localparam logic [4:0] SEL_PREPD    = 5'h03;
   localparam logic [4:0] SEL_ALIGN    = 5'h10;

   typedef enum logic [2:0] {
      SP_NOP     = 3'd0,
      SP_APPEND  = 3'd1,
      SP_PREPEND = 3'd2,
      SP_BALIGN  = 3'd3,
      SP_DAPPEND = 3'd4,
      SP_PREPW   = 3'd5,
      SP_PREPD   = 3'd6,
      SP_DBALIGN = 3'd7
   } splice_op_e;

   function automatic logic is_word_op(splice_op_e op);
      return (op == SP_APPEND) || (op == SP_PREPEND) || (op == SP_BALIGN);
   endfunction

endpackage

// File: rtl/splice_decode.sv
module splice_decode
   import splice_pkg::*;
#(
   parameter int DW_EN = 1
) (
   input  logic [5:0]  opcode,
   input  logic [5:0]  func,
   input  logic [4:0]  sel,
   output splice_op_e  op,
   output logic        act,
   output logic        rsv
);

   splice_op_e word_op;
   splice_op_e dword_op;
   logic       dword_known;

   always_comb begin
      case (sel)
         SEL_APPEND:  word_op = SP_APPEND;
         SEL_PREPEND: word_op = SP_PREPEND;
         SEL_ALIGN:   word_op = SP_BALIGN;
         default:     word_op = SP_NOP;
      endcase
   end

   generate
      if (DW_EN != 0) begin : g_dw_dec
         always_comb begin
            case (sel)
               SEL_APPEND:  dword_op = SP_DAPPEND;
               SEL_PREPEND: dword_op = SP_PREPW;
               SEL_PREPD:   dword_op = SP_PREPD;
               SEL_ALIGN:   dword_op = SP_DBALIGN;
               default:     dword_op = SP_NOP;
            endcase
         end
         assign dword_known = 1'b1;
      end else begin : g_no_dw_dec
         assign dword_op    = SP_NOP;
         assign dword_known = 1'b0;
      end
   endgenerate

   always_comb begin
      op  = SP_NOP;
      act = 1'b0;
      rsv = 1'b0;
      if (opcode == OPC_SPECIAL3) begin
         if (func == FN_WORD) begin
            op  = word_op;
            act = (word_op != SP_NOP);
            rsv = (word_op == SP_NOP);
         end else if (func == FN_DWORD) begin
            op  = dword_op;
            act = dword_known && (dword_op != SP_NOP);
            rsv = !dword_known || (dword_op == SP_NOP);
         end
      end
   end

endmodule

// File: rtl/splice_word.sv
module splice_word
   import splice_pkg::*;
(
   input  splice_op_e  op,
   input  logic [4:0]  sa,
   input  logic [31:0] rs_w,
   input  logic [31:0] rt_w,
   output logic [31:0] res_w
);

   logic [31:0] low_mask;
   logic [31:0] app_r;
   logic [31:0] prep_r;
   logic [31:0] algn_r;
   logic [1:0]  bp;
   logic [5:0]  rs_drop;

   assign low_mask = (32'd1 << sa) - 32'd1;
   assign app_r    = (rt_w << sa) | (rs_w & low_mask);
   assign prep_r   = (sa == 5'd0) ? rt_w
                   : ((rt_w >> sa) | (rs_w << (6'd32 - {1'b0, sa})));

   assign bp       = sa[1:0];
   assign rs_drop  = {3'd4 - {1'b0, bp}, 3'b000};
   assign algn_r   = bp[0] ? ((rt_w << {bp, 3'b000}) | (rs_w >> rs_drop)) : rt_w;

   always_comb begin
      case (op)
         SP_APPEND:  res_w = app_r;
         SP_PREPEND: res_w = prep_r;
         SP_BALIGN:  res_w = algn_r;
         default:    res_w = rt_w;
      endcase
   end

endmodule

// File: rtl/splice_dword.sv
module splice_dword
   import splice_pkg::*;
(
   input  splice_op_e  op,
   input  logic [4:0]  sa,
   input  logic [63:0] rs_d,
   input  logic [63:0] rt_d,
   output logic [63:0] res_d
);

   logic [63:0] low_mask;
   logic [63:0] app_r;
   logic [63:0] prepw_r;
   logic [63:0] prepd_r;
   logic [63:0] algn_r;
   logic [5:0]  dshift;
   logic [2:0]  bp;
   logic        bp_keep;
   logic [6:0]  rs_drop;

   assign low_mask = (64'd1 << sa) - 64'd1;
   assign app_r    = (rt_d << sa) | (rs_d & low_mask);
   assign prepw_r  = (sa == 5'd0) ? rt_d
                   : ((rt_d >> sa) | (rs_d << (7'd64 - {2'b00, sa})));

   assign dshift   = 6'd32 + {1'b0, sa};
   assign prepd_r  = (rt_d >> dshift) | (rs_d << (7'd64 - {1'b0, dshift}));

   assign bp       = sa[2:0];
   assign bp_keep  = (bp == 3'd0) || (bp == 3'd2) || (bp == 3'd4);
   assign rs_drop  = {4'd8 - {1'b0, bp}, 3'b000};
   assign algn_r   = bp_keep ? rt_d
                   : ((rt_d << {bp, 3'b000}) | (rs_d >> rs_drop));

   always_comb begin
      case (op)
         SP_DAPPEND: res_d = app_r;
         SP_PREPW:   res_d = prepw_r;
         SP_PREPD:   res_d = prepd_r;
         SP_DBALIGN: res_d = algn_r;
         default:    res_d = rt_d;
      endcase
   end

endmodule

// File: rtl/dsp_splice_unit.sv
module dsp_splice_unit
   import splice_pkg::*;
#(
   parameter int DW_EN = 1,
   localparam int XW   = (DW_EN != 0) ? 64 : 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [31:0]   instr,
   input  logic [XW-1:0] rs_val,
   input  logic [XW-1:0] rt_val,
   output logic [XW-1:0] out_rt,
   output logic          out_we,
   output logic          out_ri
);

   generate
      if (DW_EN != 0 && DW_EN != 1) begin : g_bad_param
         $error("dsp_splice_unit: DW_EN must be 0 or 1");
      end
   endgenerate

   splice_op_e    op;
   logic          act;
   logic          rsv;
   logic [4:0]    sa;
   logic [4:0]    rt_idx;
   logic [31:0]   word_res;
   logic [XW-1:0] word_ext;
   logic [XW-1:0] dword_res;
   logic [XW-1:0] next_rt;
   logic          fire;
   logic          unused_rs_idx;

   assign sa            = instr[15:11];
   assign rt_idx        = instr[20:16];
   assign unused_rs_idx = ^instr[25:21];

   splice_decode #(.DW_EN(DW_EN)) u_dec (
      .opcode (instr[31:26]),
      .func   (instr[5:0]),
      .sel    (instr[10:6]),
      .op     (op),
      .act    (act),
      .rsv    (rsv)
   );

   splice_word u_word (
      .op    (op),
      .sa    (sa),
      .rs_w  (rs_val[31:0]),
      .rt_w  (rt_val[31:0]),
      .res_w (word_res)
   );

   generate
      if (DW_EN != 0) begin : g_dw
         assign word_ext = {{(XW-32){word_res[31]}}, word_res};
         splice_dword u_dword (
            .op    (op),
            .sa    (sa),
            .rs_d  (rs_val),
            .rt_d  (rt_val),
            .res_d (dword_res)
         );
      end else begin : g_w
         assign word_ext  = word_res;
         assign dword_res = '0;
      end
   endgenerate

   assign next_rt = is_word_op(op) ? word_ext : dword_res;
   assign fire    = in_valid && (rt_idx != 5'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_rt <= '0;
         out_we <= 1'b0;
         out_ri <= 1'b0;
      end else begin
         out_we <= fire && act;
         out_ri <= fire && rsv;
         if (fire && act) begin
            out_rt <= next_rt;
         end
      end
   end

endmodule

// File: rtl/splice_chk.sv
module splice_chk #(
   parameter int DW_EN = 1,
   localparam int XW   = (DW_EN != 0) ? 64 : 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [31:0]   instr,
   input logic [XW-1:0] out_rt,
   input logic          out_we,
   input logic          out_ri
);

   logic unused_fields;
   assign unused_fields = ^{instr[25:21], instr[15:6]};

   // R12
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_we && out_ri));

   // R12
   flag_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_we || out_ri) |-> $past(in_valid));

   // R12
   result_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_we |-> $stable(out_rt));

   // R10
   zero_index_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[20:16] == 5'd0) |=> (!out_we && !out_ri));

   // R1
   foreign_opcode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[31:26] != 6'h1F) |=> (!out_we && !out_ri));

   generate
      if (DW_EN == 0) begin : g_w32_chk
         // R11
         dword_group_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && instr[31:26] == 6'h1F && instr[5:0] == 6'h35
             && instr[20:16] != 5'd0) |=> (out_ri && !out_we));
      end
   endgenerate

endmodule

bind dsp_splice_unit splice_chk #(.DW_EN(DW_EN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .instr    (instr),
   .out_rt   (out_rt),
   .out_we   (out_we),
   .out_ri   (out_ri)
);

// File: tb/dsp_splice_unit_bench.sv
module dsp_splice_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [63:0] rs_val = '0;
   logic [63:0] rt_val = '0;

   logic [63:0] d_rt;
   logic        d_we, d_ri;
   logic [31:0] n_rt;
   logic        n_we, n_ri;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   logic [63:0] e_rt = '0;
   logic        e_we = 1'b0, e_ri = 1'b0;
   string       e_tag = "R13";
   logic [63:0] en_rt = '0;
   logic        en_we = 1'b0, en_ri = 1'b0;
   string       en_tag = "R13";

   always #10 clk = ~clk;

   dsp_splice_unit #(.DW_EN(1)) u_dsp_splice_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .rs_val(rs_val), .rt_val(rt_val),
      .out_rt(d_rt), .out_we(d_we), .out_ri(d_ri));

   dsp_splice_unit #(.DW_EN(0)) u_dsp_splice_unit_w32 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .rs_val(rs_val[31:0]), .rt_val(rt_val[31:0]),
      .out_rt(n_rt), .out_we(n_we), .out_ri(n_ri));

   function automatic logic [31:0] mk(input logic [5:0] opc, input logic [5:0] fn,
                                      input logic [4:0] sel, input logic [4:0] sa,
                                      input logic [4:0] rti);
      return {opc, 5'd7, rti, sa, sel, fn};
   endfunction

   function automatic logic [63:0] sx(input logic [31:0] w);
      logic [63:0] r;
      for (int i = 0; i < 64; i++) r[i] = (i < 32) ? w[i] : w[31];
      return r;
   endfunction

   // behavioural model: bit-by-bit placement
   task automatic model(input logic v, input logic [31:0] ins,
                        input logic [63:0] rs, input logic [63:0] rt, input bit dw,
                        inout logic [63:0] hold, output logic we, output logic ri,
                        output string tag);
      int sa, sel, s, bp;
      logic [31:0] w;
      logic [63:0] d;
      we = 1'b0; ri = 1'b0; tag = "R12";
      sa  = int'(ins[15:11]);
      sel = int'(ins[10:6]);
      if (!v) return;
      if (ins[31:26] != 6'h1F || (ins[5:0] != 6'h31 && ins[5:0] != 6'h35)) begin
         tag = "R1"; return;
      end
      if (ins[20:16] == 5'd0) begin tag = "R10"; return; end
      if (ins[5:0] == 6'h31) begin
         if (sel == 0) begin
            tag = "R2";
            for (int i = 0; i < 32; i++) w[i] = (i < sa) ? rs[i] : rt[i-sa];
         end else if (sel == 1) begin
            tag = "R3";
            for (int i = 0; i < 32; i++) w[i] = (i < 32-sa) ? rt[i+sa] : rs[i-(32-sa)];
         end else if (sel == 16) begin
            tag = "R4";
            bp = sa % 4;
            if (bp == 0 || bp == 2) w = rt[31:0];
            else for (int k = 0; k < 4; k++)
               w[k*8 +: 8] = (k >= bp) ? rt[(k-bp)*8 +: 8] : rs[(k+4-bp)*8 +: 8];
         end else begin
            tag = "R9"; ri = 1'b1; return;
         end
         we = 1'b1;
         hold = dw ? sx(w) : {32'd0, w};
      end else begin
         if (!dw) begin tag = "R11"; ri = 1'b1; return; end
         if (sel == 0) begin
            tag = "R5";
            for (int i = 0; i < 64; i++) d[i] = (i < sa) ? rs[i] : rt[i-sa];
         end else if (sel == 1 || sel == 3) begin
            tag = (sel == 1) ? "R6" : "R7";
            s = (sel == 1) ? sa : 32 + sa;
            for (int i = 0; i < 64; i++) d[i] = (i < 64-s) ? rt[i+s] : rs[i-(64-s)];
         end else if (sel == 16) begin
            tag = "R8";
            bp = sa % 8;
            if (bp == 0 || bp == 2 || bp == 4) d = rt;
            else for (int k = 0; k < 8; k++)
               d[k*8 +: 8] = (k >= bp) ? rt[(k-bp)*8 +: 8] : rs[(k+8-bp)*8 +: 8];
         end else begin
            tag = "R9"; ri = 1'b1; return;
         end
         we = 1'b1;
         hold = d;
      end
   endtask

   task automatic compare();
      vectors++;
      if (d_we !== e_we || d_ri !== e_ri || d_rt !== e_rt) begin
         miscompares++;
         $display("FAIL %s wide: got we=%0b ri=%0b rt=%h exp we=%0b ri=%0b rt=%h",
                  e_tag, d_we, d_ri, d_rt, e_we, e_ri, e_rt);
      end
      vectors++;
      if (n_we !== en_we || n_ri !== en_ri || n_rt !== en_rt[31:0]) begin
         miscompares++;
         $display("FAIL %s narrow: got we=%0b ri=%0b rt=%h exp we=%0b ri=%0b rt=%h",
                  en_tag, n_we, n_ri, n_rt, en_we, en_ri, en_rt[31:0]);
      end
   endtask

   task automatic apply(input logic v, input logic [31:0] ins,
                        input logic [63:0] rs, input logic [63:0] rt);
      @(negedge clk);
      compare();
      in_valid = v; instr = ins; rs_val = rs; rt_val = rt;
      model(v, ins, rs, rt, 1'b1, e_rt, e_we, e_ri, e_tag);
      model(v, ins, rs, {32'd0, rt[31:0]}, 1'b0, en_rt, en_we, en_ri, en_tag);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: got running exp finished");
      finish_run();
   end

   localparam logic [63:0] A = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] B = 64'hFEDC_BA98_8765_4321;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare();                         // R13 reset state
      rst_n = 1'b1;
      // R2 / R3 extremes
      apply(1, mk(6'h1F, 6'h31, 5'h00, 5'd0,  5'd3), A, B);
      apply(1, mk(6'h1F, 6'h31, 5'h00, 5'd1,  5'd3), A, B);
      apply(1, mk(6'h1F, 6'h31, 5'h00, 5'd31, 5'd3), A, B);
      apply(1, mk(6'h1F, 6'h31, 5'h01, 5'd0,  5'd3), A, B);
      apply(1, mk(6'h1F, 6'h31, 5'h01, 5'd8,  5'd3), B, A);
      apply(1, mk(6'h1F, 6'h31, 5'h01, 5'd31, 5'd3), A, B);
      // R4 every offset, sa upper bits ignored
      for (int k = 0; k < 8; k++)
         apply(1, mk(6'h1F, 6'h31, 5'h10, 5'(k*4 + k%4), 5'd9), A, B);
      // R5..R8
      foreach (int_list[i]) begin end
      for (int s = 0; s < 32; s += 7) begin
         apply(1, mk(6'h1F, 6'h35, 5'h00, 5'(s), 5'd5), A, B);
         apply(1, mk(6'h1F, 6'h35, 5'h01, 5'(s), 5'd5), A, B);
         apply(1, mk(6'h1F, 6'h35, 5'h03, 5'(s), 5'd5), A, B);
      end
      apply(1, mk(6'h1F, 6'h35, 5'h00, 5'd31, 5'd5), B, A);
      apply(1, mk(6'h1F, 6'h35, 5'h01, 5'd31, 5'd5), B, A);
      apply(1, mk(6'h1F, 6'h35, 5'h03, 5'd31, 5'd5), B, A);
      for (int k = 0; k < 8; k++)
         apply(1, mk(6'h1F, 6'h35, 5'h10, 5'(k), 5'd6), A, B);
      // R9 reserved selectors, R10 rt index zero, R1 foreign, R12 idle
      apply(1, mk(6'h1F, 6'h31, 5'h02, 5'd4, 5'd3), A, B);
      apply(1, mk(6'h1F, 6'h35, 5'h11, 5'd4, 5'd3), A, B);
      apply(1, mk(6'h1F, 6'h31, 5'h00, 5'd4, 5'd0), A, B);
      apply(1, mk(6'h1F, 6'h35, 5'h07, 5'd4, 5'd0), A, B);
      apply(1, mk(6'h1E, 6'h31, 5'h00, 5'd4, 5'd3), A, B);
      apply(1, mk(6'h1F, 6'h30, 5'h00, 5'd4, 5'd3), A, B);
      apply(0, mk(6'h1F, 6'h31, 5'h00, 5'd4, 5'd3), A, B);
      // mixed random traffic
      for (int n = 0; n < 3000; n++) begin
         logic [4:0] sel;
         logic [5:0] fn;
         logic [5:0] opc;
         logic [4:0] rti;
         int pick;
         pick = int'($urandom_range(0, 5));
         sel = (pick == 0) ? 5'h00 : (pick == 1) ? 5'h01 : (pick == 2) ? 5'h03 :
               (pick == 3) ? 5'h10 : 5'($urandom);
         fn  = ($urandom_range(0, 9) == 0) ? 6'($urandom) :
               ($urandom_range(0, 1) == 0) ? 6'h31 : 6'h35;
         opc = ($urandom_range(0, 15) == 0) ? 6'($urandom) : 6'h1F;
         rti = ($urandom_range(0, 15) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
         apply(1'($urandom_range(0, 7) != 0), mk(opc, fn, sel, 5'($urandom), rti),
               {$urandom, $urandom}, {$urandom, $urandom});
      end
      apply(0, 32'd0, 64'd0, 64'd0);
      @(negedge clk);
      compare();
      finish_run();
   end

   int int_list[1];

endmodule